// File: doc/BRIEF.md
# Boundary-Scan Test Access Port Controller

This block is the test access port of a programmable device. A sixteen-state controller, clocked by the test clock and steered by the mode-select input, walks the standard IEEE 1149.1 state graph. A 5-bit instruction register picks which data path sits between the serial input and the serial output. The data paths are a one-bit bypass stage, a fixed 32-bit identification value, a 32-bit user code, an external boundary chain and two external user chains.

The decoded instruction also drives a few controls. One output forces every pin's output enable inactive. One marks internal-test use of the boundary chain. One is a start-up clock enable that is high for each test-clock cycle spent in Run-Test/Idle. Three outputs mirror the controller being in Test-Logic-Reset, Update-DR and Shift-DR, so logic in the device fabric can build its own scan chain. A configuration-done input controls when the two user-chain instructions and the user code become available.

Top module: `scan_tap_top`

## Requirements
- R1: The controller advances on the rising test clock according to the IEEE 1149.1 graph. The synchronous reset input, or five consecutive rising edges with mode-select high, from any state, places it in Test-Logic-Reset.
- R2: The 5-bit instruction register works as follows. In Capture-IR the shift stage loads 00001. Shift-IR shifts it LSB first, taking new bits from the serial input. The active instruction takes the shifted value at Update-IR and is set to IDCODE (01001) in Test-Logic-Reset.
- R3: The opcodes are INTEST 00111, USERCODE 01000, IDCODE 01001, HIGHZ 01010, JSTART 01100, BYPASS 11111, USER1 00010 and USER2 00011. Every other code selects the bypass stage. INTEST selects the external boundary chain (its serial output feeds the port) and raises `bnd_intest`.
- R4: The bypass stage is one bit. It captures 0 in Capture-DR, so a Shift-DR scan returns the input delayed by one clock with a leading 0.
- R5: Under IDCODE, Capture-DR loads the parameter `ID_VALUE` (LSB = 1), which then shifts out LSB first.
- R6: Under USERCODE, Capture-DR loads `user_code_in` when `cfg_done` is high and all ones when it is low.
- R7: Under HIGHZ, `pin_hiz` is high and the bypass stage is selected. Under any other instruction `pin_hiz` is low.
- R8: `startup_ce` is high in every cycle where the controller is in Run-Test/Idle with JSTART active, and low otherwise.
- R9: USER1 and USER2 act only while `cfg_done` is high. They raise `usr_sel1` or `usr_sel2` and route `usr_so1` or `usr_so2` to the port. While `cfg_done` is low they behave as BYPASS.
- R10: `usr_reset`, `usr_update` and `usr_shift` are high exactly while the controller is in Test-Logic-Reset, Update-DR and Shift-DR respectively.
- R11: `tdo` and `tdo_oe` change on the falling test clock. `tdo_oe` is high only in Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst | input | 1 | Synchronous active-high reset |
| tms | input | 1 | Mode select, sampled on rising tck |
| tdi | input | 1 | Serial data in |
| cfg_done | input | 1 | Device configuration complete |
| user_code_in | input | DR_W | User code value loaded after configuration |
| bnd_so | input | 1 | Serial output of the external boundary chain |
| usr_so1 | input | 1 | Serial output of user chain 1 |
| usr_so2 | input | 1 | Serial output of user chain 2 |
| tdo | output | 1 | Serial data out, updated on falling tck |
| tdo_oe | output | 1 | Output enable for tdo |
| pin_hiz | output | 1 | Force all pin output enables inactive |
| bnd_intest | output | 1 | Boundary chain used for internal test |
| startup_ce | output | 1 | Start-up clock enable |
| usr_sel1 | output | 1 | User chain 1 selected |
| usr_sel2 | output | 1 | User chain 2 selected |
| usr_reset | output | 1 | Controller in Test-Logic-Reset |
| usr_update | output | 1 | Controller in Update-DR |
| usr_shift | output | 1 | Controller in Shift-DR |

## Verification
The hardest case to reach is a latched USER instruction whose meaning changes when `cfg_done` rises after the instruction was loaded. The same opcode then has to act as bypass in one data scan and as a user chain in the next. The stimulus loads USER1 and USER2 with configuration low and scans a zero pattern, which must return zeros through the bypass stage. It then raises `cfg_done` without touching the instruction register and scans again, expecting the constant level of the user chain. Five-ones recovery is started from the middle of Shift-DR, the state furthest from reset.

// File: rtl/stap_pkg.sv
package stap_pkg;

    localparam int IR_W = 5;

    typedef logic [IR_W-1:0] op_t;

    localparam op_t OP_INTEST   = 5'b00111;
    localparam op_t OP_USERCODE = 5'b01000;
    localparam op_t OP_IDCODE   = 5'b01001;
    localparam op_t OP_HIGHZ    = 5'b01010;
    localparam op_t OP_JSTART   = 5'b01100;
    localparam op_t OP_BYPASS   = 5'b11111;
    localparam op_t OP_USER1    = 5'b00010;
    localparam op_t OP_USER2    = 5'b00011;
    localparam op_t IR_CAPTURE  = 5'b00001;

    typedef enum logic [3:0] {
        TS_RESET, TS_IDLE,
        TS_SEL_DR, TS_CAP_DR, TS_SHF_DR, TS_EX1_DR, TS_PAU_DR, TS_EX2_DR, TS_UPD_DR,
        TS_SEL_IR, TS_CAP_IR, TS_SHF_IR, TS_EX1_IR, TS_PAU_IR, TS_EX2_IR, TS_UPD_IR
    } tap_state_e;

    typedef enum logic [2:0] {
        DS_BYPASS, DS_IDCODE, DS_USERCODE, DS_BOUNDARY, DS_USER1, DS_USER2
    } dr_sel_e;

    typedef struct packed {
        dr_sel_e sel;
        logic    hiz;
        logic    start;
        logic    intest;
    } dec_t;

    function automatic tap_state_e tap_next(tap_state_e s, logic m);
        tap_state_e n;
        case (s)
            TS_RESET:  n = m ? TS_RESET  : TS_IDLE;
            TS_IDLE:   n = m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_DR: n = m ? TS_SEL_IR : TS_CAP_DR;
            TS_CAP_DR: n = m ? TS_EX1_DR : TS_SHF_DR;
            TS_SHF_DR: n = m ? TS_EX1_DR : TS_SHF_DR;
            TS_EX1_DR: n = m ? TS_UPD_DR : TS_PAU_DR;
            TS_PAU_DR: n = m ? TS_EX2_DR : TS_PAU_DR;
            TS_EX2_DR: n = m ? TS_UPD_DR : TS_SHF_DR;
            TS_UPD_DR: n = m ? TS_SEL_DR : TS_IDLE;
            TS_SEL_IR: n = m ? TS_RESET  : TS_CAP_IR;
            TS_CAP_IR: n = m ? TS_EX1_IR : TS_SHF_IR;
            TS_SHF_IR: n = m ? TS_EX1_IR : TS_SHF_IR;
            TS_EX1_IR: n = m ? TS_UPD_IR : TS_PAU_IR;
            TS_PAU_IR: n = m ? TS_EX2_IR : TS_PAU_IR;
            TS_EX2_IR: n = m ? TS_UPD_IR : TS_SHF_IR;
            default:   n = m ? TS_SEL_DR : TS_IDLE;
        endcase
        return n;
    endfunction

    function automatic dec_t op_decode(op_t op, logic cfg);
        dec_t d;
        d.sel    = DS_BYPASS;
        d.hiz    = 1'b0;
        d.start  = 1'b0;
        d.intest = 1'b0;
        case (op)
            OP_IDCODE:   d.sel = DS_IDCODE;
            OP_USERCODE: d.sel = DS_USERCODE;
            OP_INTEST: begin
                d.sel    = DS_BOUNDARY;
                d.intest = 1'b1;
            end
            OP_HIGHZ:    d.hiz   = 1'b1;
            OP_JSTART:   d.start = 1'b1;
            OP_USER1:    if (cfg) d.sel = DS_USER1;
            OP_USER2:    if (cfg) d.sel = DS_USER2;
            default:     d.sel = DS_BYPASS;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/stap_fsm.sv
module stap_fsm
    import stap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  logic       tms,
    output tap_state_e state
);
    always_ff @(posedge tck) begin
        if (rst) state <= TS_RESET;
        else     state <= tap_next(state, tms);
    end
endmodule

// File: rtl/stap_ir.sv
module stap_ir
    import stap_pkg::*;
(
    input  logic       tck,
    input  logic       rst,
    input  tap_state_e state,
    input  logic       tdi,
    output op_t        ir,
    output op_t        ir_sh
);
    always_ff @(posedge tck) begin
        if (rst) begin
            ir    <= OP_IDCODE;
            ir_sh <= '0;
        end else begin
            case (state)
                TS_RESET:  ir    <= OP_IDCODE;
                TS_CAP_IR: ir_sh <= IR_CAPTURE;
                TS_SHF_IR: ir_sh <= {tdi, ir_sh[IR_W-1:1]};
                TS_UPD_IR: ir    <= ir_sh;
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/stap_dr.sv
module stap_dr
    import stap_pkg::*;
#(
    parameter int          DR_W     = 32,
    parameter logic [31:0] ID_VALUE = 32'h1C0D_E0A5
) (
    input  logic            tck,
    input  logic            rst,
    input  tap_state_e      state,
    input  logic            tdi,
    input  dr_sel_e         sel,
    input  logic            cfg_done,
    input  logic [DR_W-1:0] user_code,
    output logic            so
);
    localparam logic [DR_W-1:0] ID_EXT = DR_W'(ID_VALUE);

    logic            byp_q;
    logic [DR_W-1:0] dsr_q;
    logic [DR_W-1:0] cap_val;
    logic            wide_sel;

    assign wide_sel = (sel == DS_IDCODE) || (sel == DS_USERCODE);

    always_comb begin
        if (sel == DS_IDCODE)     cap_val = ID_EXT;
        else if (cfg_done)        cap_val = user_code;
        else                      cap_val = '1;
    end

    always_ff @(posedge tck) begin
        if (rst) begin
            byp_q <= 1'b0;
            dsr_q <= '0;
        end else if (state == TS_CAP_DR) begin
            byp_q <= 1'b0;
            if (wide_sel) dsr_q <= cap_val;
        end else if (state == TS_SHF_DR) begin
            byp_q <= tdi;
            if (wide_sel) dsr_q <= {tdi, dsr_q[DR_W-1:1]};
        end
    end

    assign so = wide_sel ? dsr_q[0] : byp_q;
endmodule

// File: rtl/scan_tap_top.sv
module scan_tap_top
    import stap_pkg::*;
#(
    parameter int          DR_W     = 32,
    parameter logic [31:0] ID_VALUE = 32'h1C0D_E0A5
) (
    input  logic            tck,
    input  logic            rst,
    input  logic            tms,
    input  logic            tdi,
    input  logic            cfg_done,
    input  logic [DR_W-1:0] user_code_in,
    input  logic            bnd_so,
    input  logic            usr_so1,
    input  logic            usr_so2,
    output logic            tdo,
    output logic            tdo_oe,
    output logic            pin_hiz,
    output logic            bnd_intest,
    output logic            startup_ce,
    output logic            usr_sel1,
    output logic            usr_sel2,
    output logic            usr_reset,
    output logic            usr_update,
    output logic            usr_shift
);
    tap_state_e fsm_state;
    op_t        ir_q;
    op_t        ir_sh_q;
    dec_t       dec;
    logic       int_so;
    logic       dr_so;
    logic       out_bit;
    logic       shifting;

    stap_fsm u_fsm (
        .tck   (tck),
        .rst   (rst),
        .tms   (tms),
        .state (fsm_state)
    );

    stap_ir u_ir (
        .tck   (tck),
        .rst   (rst),
        .state (fsm_state),
        .tdi   (tdi),
        .ir    (ir_q),
        .ir_sh (ir_sh_q)
    );

    assign dec = op_decode(ir_q, cfg_done);

    stap_dr #(.DR_W(DR_W), .ID_VALUE(ID_VALUE)) u_dr (
        .tck       (tck),
        .rst       (rst),
        .state     (fsm_state),
        .tdi       (tdi),
        .sel       (dec.sel),
        .cfg_done  (cfg_done),
        .user_code (user_code_in),
        .so        (int_so)
    );

    always_comb begin
        case (dec.sel)
            DS_BOUNDARY: dr_so = bnd_so;
            DS_USER1:    dr_so = usr_so1;
            DS_USER2:    dr_so = usr_so2;
            default:     dr_so = int_so;
        endcase
    end

    assign shifting = (fsm_state == TS_SHF_IR) || (fsm_state == TS_SHF_DR);
    assign out_bit  = (fsm_state == TS_SHF_IR) ? ir_sh_q[0] : dr_so;

    always_ff @(negedge tck) begin
        if (rst) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else begin
            tdo    <= out_bit;
            tdo_oe <= shifting;
        end
    end

    assign pin_hiz    = dec.hiz;
    assign bnd_intest = dec.intest;
    assign startup_ce = dec.start && (fsm_state == TS_IDLE);
    assign usr_sel1   = (dec.sel == DS_USER1);
    assign usr_sel2   = (dec.sel == DS_USER2);
    assign usr_reset  = (fsm_state == TS_RESET);
    assign usr_update = (fsm_state == TS_UPD_DR);
    assign usr_shift  = (fsm_state == TS_SHF_DR);
endmodule

// File: rtl/scan_tap_chk.sv
module scan_tap_chk
    import stap_pkg::*;
(
    input logic       tck,
    input logic       rst,
    input logic       tms,
    input logic       cfg_done,
    input tap_state_e state,
    input op_t        ir,
    input op_t        ir_sh,
    input logic       tdo_oe,
    input logic       pin_hiz,
    input logic       startup_ce,
    input logic       usr_sel1,
    input logic       usr_sel2,
    input logic       usr_reset,
    input logic       usr_update,
    input logic       usr_shift
);
    logic [2:0] ones_cnt;

    always_ff @(posedge tck) begin
        if (rst || !tms)          ones_cnt <= '0;
        else if (ones_cnt != 3'd5) ones_cnt <= ones_cnt + 3'd1;
    end

    AST_FIVE_ONES_RESET: assert property (@(posedge tck) disable iff (rst)
        (ones_cnt == 3'd5) |-> usr_reset); // R1

    AST_IR_TAKES_SHIFT: assert property (@(posedge tck) disable iff (rst)
        (state == TS_UPD_IR) |=> (ir == $past(ir_sh))); // R2

    AST_TLR_LOADS_ID: assert property (@(posedge tck) disable iff (rst)
        usr_reset |=> (ir == OP_IDCODE)); // R2

    AST_HIGHZ_ONLY: assert property (@(posedge tck) disable iff (rst)
        pin_hiz |-> (ir == OP_HIGHZ)); // R7

    AST_START_IN_IDLE: assert property (@(posedge tck) disable iff (rst)
        startup_ce |-> (state == TS_IDLE && ir == OP_JSTART)); // R8

    AST_USER_GATED: assert property (@(posedge tck) disable iff (rst)
        !cfg_done |-> !(usr_sel1 || usr_sel2)); // R9

    AST_MIRROR_ONEHOT: assert property (@(posedge tck) disable iff (rst)
        $onehot0({usr_reset, usr_update, usr_shift})); // R10

    AST_OE_IN_SHIFT: assert property (@(posedge tck) disable iff (rst)
        tdo_oe |-> (usr_shift || state == TS_SHF_IR)); // R11
endmodule

bind scan_tap_top scan_tap_chk chk_i (
    .tck        (tck),
    .rst        (rst),
    .tms        (tms),
    .cfg_done   (cfg_done),
    .state      (fsm_state),
    .ir         (ir_q),
    .ir_sh      (ir_sh_q),
    .tdo_oe     (tdo_oe),
    .pin_hiz    (pin_hiz),
    .startup_ce (startup_ce),
    .usr_sel1   (usr_sel1),
    .usr_sel2   (usr_sel2),
    .usr_reset  (usr_reset),
    .usr_update (usr_update),
    .usr_shift  (usr_shift)
);

// File: tb/scan_tap_top_tb_top.sv
module scan_tap_top_tb_top;
    localparam logic [31:0] ID = 32'h1C0D_E0A5;

    logic        tck = 1'b0;
    logic        rst = 1'b1;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        cfg_done = 1'b0;
    logic [31:0] user_code_in = 32'h5A3C_9617;
    logic        bnd_so = 1'b1;
    logic        usr_so1 = 1'b1;
    logic        usr_so2 = 1'b1;
    logic tdo, tdo_oe, pin_hiz, bnd_intest, startup_ce;
    logic usr_sel1, usr_sel2, usr_reset, usr_update, usr_shift;

    int checks = 0;
    int fails  = 0;

    // reference model state
    int         m_st = 0;
    logic [4:0] m_ir = 5'b01001;
    logic [4:0] m_irsh = '0;
    logic       m_byp = 1'b0;
    logic [31:0] m_dsr = '0;

    always #10 tck = ~tck;

    scan_tap_top #(.DR_W(32), .ID_VALUE(ID)) dut_i (
        .tck(tck), .rst(rst), .tms(tms), .tdi(tdi), .cfg_done(cfg_done),
        .user_code_in(user_code_in), .bnd_so(bnd_so), .usr_so1(usr_so1),
        .usr_so2(usr_so2), .tdo(tdo), .tdo_oe(tdo_oe), .pin_hiz(pin_hiz),
        .bnd_intest(bnd_intest), .startup_ce(startup_ce), .usr_sel1(usr_sel1),
        .usr_sel2(usr_sel2), .usr_reset(usr_reset), .usr_update(usr_update),
        .usr_shift(usr_shift)
    );

    function automatic int nxt(int s, logic m);
        case (s)
            0: return m ? 0 : 1;
            1: return m ? 2 : 1;
            2: return m ? 9 : 3;
            3, 4: return m ? 5 : 4;
            5: return m ? 8 : 6;
            6: return m ? 7 : 6;
            7: return m ? 8 : 4;
            9: return m ? 0 : 10;
            10, 11: return m ? 12 : 11;
            12: return m ? 15 : 13;
            13: return m ? 14 : 13;
            14: return m ? 15 : 11;
            default: return m ? 2 : 1;
        endcase
    endfunction

    // 0 bypass, 1 id, 2 usercode, 3 boundary, 4 user1, 5 user2
    function automatic int msel(logic [4:0] op, logic cfg);
        case (op)
            5'b01001: return 1;
            5'b01000: return 2;
            5'b00111: return 3;
            5'b00010: return cfg ? 4 : 0;
            5'b00011: return cfg ? 5 : 0;
            default:  return 0;
        endcase
    endfunction

    task automatic chk(input string req, input string nm, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, nm, act, exp);
        end
    endtask

    task automatic model_step(input logic m, input logic d);
        int s;
        s = m_st;
        if (rst) begin
            m_st = 0; m_ir = 5'b01001; m_irsh = '0; m_byp = 1'b0; m_dsr = '0;
            return;
        end
        case (s)
            0:  m_ir = 5'b01001;
            10: m_irsh = 5'b00001;
            11: m_irsh = {d, m_irsh[4:1]};
            15: m_ir = m_irsh;
            3: begin
                m_byp = 1'b0;
                if (msel(m_ir, cfg_done) == 1) m_dsr = ID;
                else if (msel(m_ir, cfg_done) == 2) m_dsr = cfg_done ? user_code_in : 32'hFFFF_FFFF;
            end
            4: begin
                m_byp = d;
                if (msel(m_ir, cfg_done) inside {1, 2}) m_dsr = {d, m_dsr[31:1]};
            end
            default: ;
        endcase
        m_st = nxt(s, m);
    endtask

    task automatic compare_all();
        logic eo;
        logic et;
        int   sl;
        sl = msel(m_ir, cfg_done);
        eo = (m_st == 4) || (m_st == 11);
        chk("R11", "tdo_oe", 64'(tdo_oe), 64'(eo));
        chk("R10", "usr_reset", 64'(usr_reset), 64'(m_st == 0));
        chk("R10", "usr_update", 64'(usr_update), 64'(m_st == 8));
        chk("R10", "usr_shift", 64'(usr_shift), 64'(m_st == 4));
        chk("R7", "pin_hiz", 64'(pin_hiz), 64'(m_ir == 5'b01010));
        chk("R8", "startup_ce", 64'(startup_ce), 64'(m_ir == 5'b01100 && m_st == 1));
        chk("R9", "usr_sel1", 64'(usr_sel1), 64'(sl == 4));
        chk("R9", "usr_sel2", 64'(usr_sel2), 64'(sl == 5));
        chk("R3", "bnd_intest", 64'(bnd_intest), 64'(m_ir == 5'b00111));
        if (eo) begin
            if (m_st == 11)         et = m_irsh[0];
            else if (sl inside {1, 2}) et = m_dsr[0];
            else if (sl == 3)       et = bnd_so;
            else if (sl == 4)       et = usr_so1;
            else if (sl == 5)       et = usr_so2;
            else                    et = m_byp;
            chk("R11", "tdo", 64'(tdo), 64'(et));
        end
    endtask

    task automatic tick(input logic m, input logic d, output logic seen);
        tms = m;
        tdi = d;
        @(posedge tck);
        model_step(m, d);
        @(negedge tck);
        #1;
        compare_all();
        seen = tdo;
    endtask

    task automatic load_ir(input logic [4:0] op, output logic [4:0] cap);
        logic s;
        tick(1'b1, 1'b0, s); tick(1'b1, 1'b0, s);
        tick(1'b0, 1'b0, s); tick(1'b0, 1'b0, s);
        cap[0] = s;
        for (int k = 0; k < 5; k++) begin
            tick(k == 4, op[k], s);
            if (k < 4) cap[k+1] = s;
        end
        tick(1'b1, 1'b0, s); tick(1'b0, 1'b0, s);
    endtask

    task automatic scan_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic s;
        dout = '0;
        tick(1'b1, 1'b0, s); tick(1'b0, 1'b0, s); tick(1'b0, 1'b0, s);
        dout[0] = s;
        for (int k = 0; k < n; k++) begin
            tick(k == n - 1, din[k], s);
            if (k < n - 1) dout[k+1] = s;
        end
        tick(1'b1, 1'b0, s); tick(1'b0, 1'b0, s);
    endtask

    initial begin
        repeat (100000) @(posedge tck);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic        s;
        logic [4:0]  cap;
        logic [63:0] q;
        @(negedge tck); #1;
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, s);
        rst = 1'b0;
        chk("R1", "reset state usr_reset", 64'(usr_reset), 64'd1);
        chk("R11", "reset tdo_oe", 64'(tdo_oe), 64'd0);
        tick(1'b0, 1'b0, s);

        // R2 / R5: IDCODE is default after reset
        scan_dr(32, 64'h0, q);
        chk("R5", "idcode after reset", q[31:0], 64'(ID));

        // R2: capture pattern; R4: bypass delay
        load_ir(5'b11111, cap);
        chk("R2", "ir capture", 64'(cap), 64'h01);
        scan_dr(8, 64'hB5, q);
        chk("R4", "bypass scan", q[7:0], 64'h6A);

        // R6: usercode before and after configuration
        load_ir(5'b01000, cap);
        scan_dr(32, 64'h0, q);
        chk("R6", "usercode unconfigured", q[31:0], 64'hFFFF_FFFF);
        cfg_done = 1'b1;
        scan_dr(32, 64'h0, q);
        chk("R6", "usercode configured", q[31:0], 64'(user_code_in));
        cfg_done = 1'b0;

        // R3: reserved code acts as bypass
        load_ir(5'b10101, cap);
        scan_dr(8, 64'hC3, q);
        chk("R3", "reserved as bypass", q[7:0], 64'h86);

        // R7: HIGHZ
        load_ir(5'b01010, cap);
        chk("R7", "highz pin_hiz", 64'(pin_hiz), 64'd1);
        scan_dr(8, 64'h5F, q);
        chk("R7", "highz bypass path", q[7:0], 64'hBE);

        // R8: JSTART
        load_ir(5'b01100, cap);
        for (int i = 0; i < 3; i++) begin
            tick(1'b0, 1'b0, s);
            chk("R8", "startup_ce in idle", 64'(startup_ce), 64'd1);
        end
        tick(1'b1, 1'b0, s);
        chk("R8", "startup_ce off idle", 64'(startup_ce), 64'd0);
        tick(1'b0, 1'b0, s); tick(1'b0, 1'b0, s); tick(1'b1, 1'b0, s);
        tick(1'b1, 1'b0, s); tick(1'b0, 1'b0, s);

        // R9: USER1/USER2 gated by configuration
        load_ir(5'b00010, cap);
        scan_dr(8, 64'h0, q);
        chk("R9", "user1 unconfigured bypass", q[7:0], 64'h00);
        cfg_done = 1'b1;
        tick(1'b0, 1'b0, s);
        chk("R9", "user1 select", 64'(usr_sel1), 64'd1);
        scan_dr(8, 64'h0, q);
        chk("R9", "user1 chain data", q[7:0], 64'hFF);
        cfg_done = 1'b0;
        load_ir(5'b00011, cap);
        scan_dr(8, 64'h0, q);
        chk("R9", "user2 unconfigured bypass", q[7:0], 64'h00);
        cfg_done = 1'b1;
        scan_dr(8, 64'h0, q);
        chk("R9", "user2 chain data", q[7:0], 64'hFF);

        // R3: INTEST routes boundary chain
        load_ir(5'b00111, cap);
        chk("R3", "intest flag", 64'(bnd_intest), 64'd1);
        bnd_so = 1'b0;
        scan_dr(8, 64'hFF, q);
        chk("R3", "intest boundary data", q[7:0], 64'h00);
        bnd_so = 1'b1;

        // R1: five ones from inside Shift-DR
        tick(1'b1, 1'b0, s); tick(1'b0, 1'b0, s); tick(1'b0, 1'b0, s);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, s);
        chk("R1", "five ones reach reset", 64'(usr_reset), 64'd1);
        tick(1'b0, 1'b0, s);
        scan_dr(32, 64'h0, q);
        chk("R2", "idcode restored by reset state", q[31:0], 64'(ID));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule